// File: doc/BRIEF.md
# MAC Control Frame Transmitter

This block sends one MAC control frame, normally a pause request, when software asks for it. Software first loads three 48-bit table slots. One slot holds the destination address, one holds the source address, and one holds the type, opcode and operand words. Software then sets a send bit in the transmit control register. The block waits until any data frame on the shared transmit path has finished. It then streams the frame body one byte per handshake over a valid/ready/last interface.

The frame body is always 60 bytes. The first 18 bytes come from the table. Every byte after that is zero: first the two bytes after the operand, then the reserved words, then padding. The downstream CRC stage brings the frame to the 64-byte minimum. Because every field comes from a table slot, the same path can send other MAC control opcodes without any change to the logic.

When the frame ends, the block writes a two-bit status word and clears the send bit. The frame ends either normally or because software drops the transmit enable part way through. If the interrupt enable bit is set, the block also gives a one-cycle interrupt pulse.

Top module: `ctl_frame_tx`

## Requirements
- R1: After reset, `tx_valid_o`, `tx_last_o` and `irq_o` are low, and `ctrl_o` and `stat_o` read zero.
- R2: A table write with index 0 loads the destination slot, index 1 loads the source slot and index 18 loads the control-word slot. A write with any other index changes no transmitted byte.
- R3: Byte order of the frame body:
  - Bytes 0-5 are the destination slot, most significant byte first.
  - Bytes 6-11 are the source slot in the same order.
  - Bytes 12-17 are the control-word slot, bits [47:32] type, [31:16] opcode, [15:0] operand, most significant byte first.
  - Bytes 18-59 are zero.
- R4: A frame carries exactly 60 handshaked bytes. `tx_last_o` is high only with byte 59, and no byte is offered after it.
- R5: A byte is consumed only when `tx_valid_o` and `tx_ready_i` are both high. While the sink stalls, `tx_data_o` and `tx_last_o` hold their values.
- R6: Transmission starts only when all of these hold:
  - the send bit (ctrl bit 0) is set;
  - transmit enable (ctrl bit 2) is set;
  - `mac_busy_i` is low.

  Until then the request stays pending.
- R7: Writing 1 to ctrl bit 0 sets the send bit; writing 0 to it has no effect. The send bit clears itself when the frame completes or aborts.
- R8: At completion `stat_o` becomes 2'b01 (bit 0 = done). At abort it becomes 2'b10 (bit 1 = aborted).
- R9: Clearing transmit enable during a frame drops `tx_valid_o` in the cycle the enable reads low and ends the frame without `tx_last_o`.
- R10: `irq_o` pulses for one cycle after a completion or abort only if interrupt enable (ctrl bit 1) was set. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_we_i | input | 1 | Table slot write strobe |
| slot_idx_i | input | 5 | Table slot index |
| slot_wdata_i | input | 48 | Table slot write data |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control write data: bit 0 send, bit 1 interrupt enable, bit 2 transmit enable |
| ctrl_o | output | 3 | Control register readback |
| stat_o | output | 2 | Control-frame status: bit 0 done, bit 1 aborted |
| irq_o | output | 1 | Completion interrupt pulse |
| mac_busy_i | input | 1 | A data frame currently owns the transmit path |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit sink ready |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of the frame |

## Verification
A wrong byte index shows up as a mismatch or a misplaced last flag in the scoreboard on the very next handshake. An index that fails to hold during a stall is caught the cycle after the stall.

A send bit that does not clear shows as a second, unrequested frame within two cycles of the first one ending. A status or interrupt that is written late or not at all shows on `stat_o` and `irq_o` one cycle after the last byte or the abort.

An early start is visible as `tx_valid_o` rising while `mac_busy_i` or the enable still forbids it. The bench watches for this over long pending windows.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;
  localparam int SLOT_W   = 48;
  localparam int N_FIELDS = 3;
  localparam int CTRL_SEND = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_TXEN = 2;

  typedef struct packed {
    logic aborted;
    logic done;
  } stat_t;
endpackage

// File: rtl/cf_slot_regs.sv
module cf_slot_regs #(
  parameter int SLOT_W     = 48,
  parameter int SLOT_IDX_W = 5,
  parameter int DA_SLOT    = 0,
  parameter int SA_SLOT    = 1,
  parameter int CW_SLOT    = 18,
  localparam int N_FIELDS  = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [SLOT_IDX_W-1:0]            idx_i,
  input  logic [SLOT_W-1:0]                wdata_i,
  output logic [N_FIELDS-1:0][SLOT_W-1:0]  fields_o
);
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_slot
    localparam int SI = (g == 0) ? DA_SLOT : (g == 1) ? SA_SLOT : CW_SLOT;
    logic [SLOT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (we_i && idx_i == SLOT_IDX_W'(SI))    q <= wdata_i;
    end
    assign fields_o[g] = q;
  end
endmodule

// File: rtl/cf_byte_mux.sv
module cf_byte_mux #(
  parameter int SLOT_W   = 48,
  parameter int N_FIELDS = 3,
  parameter int IDX_W    = 6,
  localparam int FB      = SLOT_W / 8
) (
  input  logic [N_FIELDS-1:0][SLOT_W-1:0] fields_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [7:0]                      byte_o
);
  // table bytes first, everything past them reads as zero
  always_comb begin
    byte_o = '0;
    for (int f = 0; f < N_FIELDS; f++) begin
      for (int b = 0; b < FB; b++) begin
        if (int'(idx_i) == f * FB + b) byte_o = fields_i[f][SLOT_W-1-8*b -: 8];
      end
    end
  end
endmodule

// File: rtl/cf_ctrl.sv
module cf_ctrl
  import ctl_frame_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  wdata_i,
  input  logic        done_i,
  input  logic        abort_i,
  output logic        send_o,
  output logic        ie_o,
  output logic        txen_o,
  output stat_t       stat_o,
  output logic        irq_o
);
  logic send_q, ie_q, txen_q, irq_q;
  stat_t stat_q;
  logic fin;

  assign fin = done_i | abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_q <= 1'b0;
      ie_q   <= 1'b0;
      txen_q <= 1'b0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (we_i) begin
        ie_q   <= wdata_i[CTRL_IE];
        txen_q <= wdata_i[CTRL_TXEN];
        if (wdata_i[CTRL_SEND]) send_q <= 1'b1;
      end
      if (fin) begin
        send_q <= 1'b0;   // completion wins over a concurrent set
        stat_q <= '{aborted: abort_i, done: done_i};
      end
      irq_q <= fin & ie_q;
    end
  end

  assign send_o = send_q;
  assign ie_o   = ie_q;
  assign txen_o = txen_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cf_serializer.sv
module cf_serializer #(
  parameter int FRAME_BYTES = 60,
  localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic             txen_i,
  input  logic             mac_busy_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             active_o,
  output logic             done_o,
  output logic             abort_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             start, hs, at_last;

  assign start   = !active_q && send_i && txen_i && !mac_busy_i;
  assign at_last = (idx_q == LAST_IDX);
  assign hs      = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (abort_o) begin
      active_q <= 1'b0;
    end else if (hs) begin
      if (at_last) active_q <= 1'b0;
      else         idx_q    <= idx_q + 1'b1;
    end
  end

  assign tx_valid_o = active_q && txen_i;
  assign tx_last_o  = tx_valid_o && at_last;
  assign done_o     = hs && at_last;
  assign abort_o    = active_q && !txen_i;
  assign idx_o      = idx_q;
  assign active_o   = active_q;
endmodule

// File: rtl/ctl_frame_tx.sv
module ctl_frame_tx
  import ctl_frame_pkg::*;
#(
  parameter int SLOT_IDX_W  = 5,
  parameter int DA_SLOT     = 0,
  parameter int SA_SLOT     = 1,
  parameter int CW_SLOT     = 18,
  parameter int FRAME_BYTES = 60
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  slot_we_i,
  input  logic [SLOT_IDX_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0]     slot_wdata_i,
  input  logic                  ctrl_we_i,
  input  logic [2:0]            ctrl_wdata_i,
  output logic [2:0]            ctrl_o,
  output logic [1:0]            stat_o,
  output logic                  irq_o,
  input  logic                  mac_busy_i,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic [7:0]            tx_data_o,
  output logic                  tx_last_o
);
  localparam int IDX_W = $clog2(FRAME_BYTES);

  logic [N_FIELDS-1:0][SLOT_W-1:0] fields;
  logic [IDX_W-1:0] idx;
  logic send, ie, txen, active, done_pulse, abort_pulse;
  stat_t stat;

  cf_slot_regs #(
    .SLOT_W(SLOT_W), .SLOT_IDX_W(SLOT_IDX_W),
    .DA_SLOT(DA_SLOT), .SA_SLOT(SA_SLOT), .CW_SLOT(CW_SLOT)
  ) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(slot_we_i),
    .idx_i(slot_idx_i), .wdata_i(slot_wdata_i), .fields_o(fields)
  );

  cf_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl_we_i), .wdata_i(ctrl_wdata_i),
    .done_i(done_pulse), .abort_i(abort_pulse),
    .send_o(send), .ie_o(ie), .txen_o(txen), .stat_o(stat), .irq_o(irq_o)
  );

  cf_serializer #(.FRAME_BYTES(FRAME_BYTES)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .send_i(send), .txen_i(txen),
    .mac_busy_i(mac_busy_i), .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o), .idx_o(idx),
    .active_o(active), .done_o(done_pulse), .abort_o(abort_pulse)
  );

  cf_byte_mux #(.SLOT_W(SLOT_W), .N_FIELDS(N_FIELDS), .IDX_W(IDX_W)) u_mux (
    .fields_i(fields), .idx_i(idx), .byte_o(tx_data_o)
  );

  assign ctrl_o = {txen, ie, send};
  assign stat_o = stat;
endmodule

// File: rtl/ctl_frame_tx_chk.sv
module ctl_frame_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] ctrl_o,
  input logic [1:0] stat_o,
  input logic       irq_o,
  input logic       mac_busy_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_last_o,
  input logic       active_i,
  input logic       done_i,
  input logic       abort_i
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o); // R4
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (tx_last_o && tx_ready_i)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (!tx_valid_o || ($stable(tx_data_o) && $stable(tx_last_o)))); // R5
  AST_START_ALLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> $past(!mac_busy_i && ctrl_o[0] && ctrl_o[2])); // R6
  AST_SEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || abort_i) |=> !ctrl_o[0]); // R7
  AST_STAT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_o)); // R8
  AST_ABORT_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (stat_o == 2'b10)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_o[1] && (done_i || abort_i))); // R10
endmodule

bind ctl_frame_tx ctl_frame_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_o(ctrl_o), .stat_o(stat_o), .irq_o(irq_o),
  .mac_busy_i(mac_busy_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .active_i(active), .done_i(done_pulse), .abort_i(abort_pulse)
);

// File: tb/test_ctl_frame_tx.sv
module test_ctl_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_we = 1'b0, ctrl_we = 1'b0, mac_busy = 1'b0, tx_ready = 1'b1;
  logic [4:0] slot_idx = '0;
  logic [47:0] slot_wd = '0;
  logic [2:0] ctrl_wd = '0, ctrl;
  logic [1:0] stat;
  logic irq, tx_valid, tx_last;
  logic [7:0] tx_data;

  int total = 0, bad = 0;
  int valid_cnt = 0, hs_cnt = 0, irq_cnt = 0, last_cnt = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0] exp_q[$];
  logic prev_stall = 1'b0;
  logic [8:0] prev_byte = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  ctl_frame_tx i_ctl_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .slot_we_i(slot_we), .slot_idx_i(slot_idx),
    .slot_wdata_i(slot_wd), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .ctrl_o(ctrl), .stat_o(stat), .irq_o(irq), .mac_busy_i(mac_busy),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_last_o(tx_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) valid_cnt++;
      if (irq) irq_cnt++;
      if (tx_last && tx_valid && tx_ready) last_cnt++;
      if (prev_stall && tx_valid)
        chk({tx_last, tx_data} == prev_byte, "R5 stall hold", {tx_last, tx_data}, prev_byte);
      prev_stall = tx_valid && !tx_ready;
      prev_byte  = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) chk(0, "R4 unexpected byte", {tx_last, tx_data}, 0);
        else begin
          automatic logic [8:0] e = exp_q.pop_front();
          chk({tx_last, tx_data} == e, "R3 R4 frame byte", {tx_last, tx_data}, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_slot(input logic [4:0] idx, input logic [47:0] d);
    @(posedge clk); #1;
    slot_we = 1'b1; slot_idx = idx; slot_wd = d;
    @(posedge clk); #1;
    slot_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [2:0] d);
    @(posedge clk); #1;
    ctrl_we = 1'b1; ctrl_wd = d;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
  endtask

  task automatic push_frame(input logic [47:0] da, input logic [47:0] sa, input logic [47:0] cw);
    logic [143:0] hdr = {da, sa, cw};
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b = (i < 18) ? hdr[143-8*i -: 8] : 8'h00;
      exp_q.push_back({(i == 59), b});
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R4 frame drained", exp_q.size(), 0);
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] da = 48'h0180C2000001, sa = 48'h001122334455;
    logic [47:0] cw = 48'h88080001ABCD;
    int v0, i0, l0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !tx_last && !irq, "R1 outputs idle", {tx_valid, tx_last, irq}, 0);
    chk(ctrl == 0 && stat == 0, "R1 regs zero", {ctrl, stat}, 0);

    wr_slot(5'd0, da); wr_slot(5'd1, sa); wr_slot(5'd18, cw);
    wr_slot(5'd5, 48'hFFFFFFFFFFFF); wr_slot(5'd17, 48'hDEADBEEF0000); wr_slot(5'd19, 48'h123456789ABC);

    // A: plain send, interrupt enabled, R2 ignored writes checked by bytes
    v0 = valid_cnt; i0 = irq_cnt;
    push_frame(da, sa, cw);
    wr_ctrl(3'b111);
    drain();
    chk(stat == 2'b01, "R8 done status", stat, 2'b01);
    chk(ctrl[0] == 1'b0, "R7 send self clear", ctrl, 3'b110);
    chk(irq_cnt - i0 == 1, "R10 irq pulse", irq_cnt - i0, 1);
    chk(valid_cnt - v0 == 60, "R4 sixty bytes", valid_cnt - v0, 60);

    // B: backpressure, new control word, interrupt masked
    cw = 48'h880800010000;
    wr_slot(5'd18, cw);
    rdy_mode = 1; i0 = irq_cnt;
    push_frame(da, sa, cw);
    wr_ctrl(3'b101);
    drain();
    chk(irq_cnt == i0, "R10 masked irq", irq_cnt - i0, 0);
    chk(stat == 2'b01, "R8 done status B", stat, 2'b01);

    // C: request held off by a busy data frame
    rdy_mode = 0; mac_busy = 1'b1; v0 = valid_cnt;
    da = 48'hA1A2A3A4A5A6; wr_slot(5'd0, da);
    push_frame(da, sa, cw);
    wr_ctrl(3'b111);
    cyc(20);
    chk(valid_cnt == v0, "R6 wait for busy", valid_cnt - v0, 0);
    chk(ctrl[0] == 1'b1, "R6 request pending", ctrl, 3'b111);
    mac_busy = 1'b0;
    drain();

    // D: request held off by transmit disable, zero write to send ignored
    v0 = valid_cnt;
    push_frame(da, sa, cw);
    wr_ctrl(3'b011);
    cyc(10);
    chk(valid_cnt == v0, "R6 wait for enable", valid_cnt - v0, 0);
    wr_ctrl(3'b110);
    chk(ctrl[0] == 1'b1 || valid_cnt != v0, "R7 zero write no clear", ctrl, 3'b111);
    drain();

    // E: abort mid frame
    i0 = irq_cnt; l0 = last_cnt;
    push_frame(da, sa, cw);
    v0 = hs_cnt;
    wr_ctrl(3'b111);
    for (int i = 0; i < 500 && hs_cnt < v0 + 10; i++) @(negedge clk);
    wr_ctrl(3'b010);
    @(negedge clk);
    chk(!tx_valid, "R9 valid drops", tx_valid, 0);
    cyc(4);
    exp_q.delete();
    chk(stat == 2'b10, "R8 abort status", stat, 2'b10);
    chk(ctrl[0] == 1'b0, "R7 clear on abort", ctrl, 3'b010);
    chk(irq_cnt - i0 == 1, "R10 irq on abort", irq_cnt - i0, 1);
    chk(last_cnt == l0, "R9 no last on abort", last_cnt - l0, 0);

    // F: re-enable without a new request sends nothing
    v0 = valid_cnt;
    wr_ctrl(3'b100);
    cyc(10);
    chk(valid_cnt == v0, "R7 no resend after abort", valid_cnt - v0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule